// File: doc/BRIEF.md
# Nibble-Stream Ethernet Frame Integrity Checker

This block watches the receive side of a 100 Mbit media-independent interface, where the PHY supplies a 25 MHz clock and one 4-bit nibble per cycle while its data-valid line is high. It skips the preamble and locks onto the start-of-frame delimiter. It then pairs nibbles into bytes and feeds every byte, from the first address byte through the four-byte frame check sequence, into a byte-wide CRC-32 engine.

The engine uses the IEEE 802.3 polynomial in its bit-reflected, LSB-first form. It is preset to all ones. When data-valid drops, the block raises a one-cycle `frame_done` strobe. Alongside that strobe, `fcs_ok` reports whether the register holds the fixed good-frame residue, and `odd_nibble_err` reports a frame that ended halfway through a byte. On the following cycle the block latches two values for inspection: the four FCS bytes it received, and the FCS it computed itself. The computed value is taken from the CRC state before the last four bytes, complemented and put in wire order.

Top module: `mii_fcs_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, `frame_done`, `fcs_ok`, `odd_nibble_err`, `rx_fcs` and `calc_fcs` are all zero.
- R2: Nibbles before the delimiter nibble 0xD have no effect on results. The preamble may hold any number of 0x5 nibbles, including none. If data-valid falls before a 0xD has been seen, no `frame_done` is produced and the latched values are unchanged.
- R3: After the delimiter, the first nibble of each pair is the low half of a byte and the second nibble is the high half.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7, processed LSB first, preset to 0xFFFFFFFF, with a final complement. For the payload bytes ASCII "123456789", `calc_fcs` equals 0x2639F4CB.
- R5: Because of the preset, a payload made only of zero bytes gives a nonzero computed FCS, and that value differs between payload lengths of 8 and 16 bytes.
- R6: A frame whose last four bytes are the correct FCS of the bytes before them gives `fcs_ok`=1 together with `frame_done`. The check compares the un-complemented register with the residue 0xC704DD7B, held in bit-reversed form.
- R7: A frame whose payload has been altered after its FCS was computed gives `fcs_ok`=0 with `frame_done`=1.
- R8: `frame_done` is high for exactly one cycle. That cycle is the one after the first clock edge at which data-valid is sampled low following a delimiter.
- R9: If the frame ends with an unpaired nibble, the leftover nibble is dropped, `odd_nibble_err`=1 and `fcs_ok`=0.
- R10: One cycle after `frame_done`, `rx_fcs` holds the last four received bytes and `calc_fcs` holds the complemented pre-FCS CRC as wire bytes. In both values the first byte on the wire sits in bits [31:24]. Both values hold until the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_nib | input | 4 | Receive nibble |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| fcs_ok | output | 1 | Residue matched, valid with frame_done |
| odd_nibble_err | output | 1 | Frame ended mid-byte, valid with frame_done |
| rx_fcs | output | 32 | Received FCS bytes, first wire byte high |
| calc_fcs | output | 32 | Computed FCS, wire order, first byte high |

## Verification
The assertions assume that data-valid stays high for a whole frame and then falls. They also assume that a match against the residue only happens for frames at least four bytes long, so the latched received and computed FCS are equal whenever `fcs_ok` fires. The stimulus keeps within these limits. It drives one nibble per cycle with data-valid continuously high from the preamble to the last nibble, and it leaves at least three idle cycles between frames. Every frame it sends as good carries a true FCS computed by the bench's own MSB-first CRC model. Frames sent as bad differ from good ones only by a flipped payload bit or a trailing nibble.

// File: rtl/fcs_chk_pkg.sv
package fcs_chk_pkg;

    localparam int NIB_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 32;
    localparam int FCS_BYTES = CRC_W / BYTE_W;

    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } byte_beat_t;

    function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    localparam logic [CRC_W-1:0] POLY_NORM  = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] POLY_REF   = bit_rev(POLY_NORM);
    localparam logic [CRC_W-1:0] RESID_NORM = 32'hC704_DD7B;
    localparam logic [CRC_W-1:0] RESID_REF  = bit_rev(RESID_NORM);
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, d};
        for (int i = 0; i < BYTE_W; i++)
            r = r[0] ? ((r >> 1) ^ POLY_REF) : (r >> 1);
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] to_wire(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] w;
        for (int b = 0; b < FCS_BYTES; b++)
            w[CRC_W-1-b*BYTE_W -: BYTE_W] = c[b*BYTE_W +: BYTE_W];
        return w;
    endfunction

endpackage

// File: rtl/mii_nibble_packer.sv
module mii_nibble_packer
    import fcs_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_dv,
    input  logic [NIB_W-1:0] rx_nib,
    output logic             sof,
    output byte_beat_t       beat,
    output logic             eof,
    output logic             odd
);

    rx_state_e        state_q;
    logic             half_q;
    logic [NIB_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            half_q  <= 1'b0;
            low_q   <= '0;
            sof     <= 1'b0;
            beat    <= '0;
            eof     <= 1'b0;
            odd     <= 1'b0;
        end else begin
            sof      <= 1'b0;
            beat.vld <= 1'b0;
            eof      <= 1'b0;
            odd      <= 1'b0;
            case (state_q)
                ST_HUNT: begin
                    if (rx_dv && rx_nib == SFD_NIB) begin
                        state_q <= ST_DATA;
                        half_q  <= 1'b0;
                        sof     <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (!rx_dv) begin
                        state_q <= ST_HUNT;
                        eof     <= 1'b1;
                        odd     <= half_q;
                        half_q  <= 1'b0;
                    end else if (!half_q) begin
                        low_q  <= rx_nib;
                        half_q <= 1'b1;
                    end else begin
                        beat.vld <= 1'b1;
                        beat.dat <= {rx_nib, low_q};
                        half_q   <= 1'b0;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
    import fcs_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  byte_beat_t       beat,
    output logic [CRC_W-1:0] crc_now,
    output logic             resid_hit
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)           crc_q <= CRC_PRESET;
        else if (start)    crc_q <= CRC_PRESET;
        else if (beat.vld) crc_q <= crc_step(crc_q, beat.dat);
    end

    assign crc_now   = crc_q;
    assign resid_hit = (crc_q == RESID_REF);

endmodule

// File: rtl/fcs_capture.sv
module fcs_capture
    import fcs_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  byte_beat_t       beat,
    input  logic [CRC_W-1:0] crc_now,
    input  logic             eof,
    output logic [CRC_W-1:0] rx_fcs,
    output logic [CRC_W-1:0] calc_fcs
);

    logic [CRC_W-1:0] hist_q [FCS_BYTES];
    logic [CRC_W-1:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            for (int i = 0; i < FCS_BYTES; i++) hist_q[i] <= CRC_PRESET;
            tail_q <= '0;
        end else if (beat.vld) begin
            hist_q[0] <= crc_now;
            for (int i = 1; i < FCS_BYTES; i++) hist_q[i] <= hist_q[i-1];
            tail_q <= {tail_q[CRC_W-BYTE_W-1:0], beat.dat};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_fcs   <= '0;
            calc_fcs <= '0;
        end else if (eof) begin
            rx_fcs   <= tail_q;
            calc_fcs <= to_wire(~hist_q[FCS_BYTES-1]);
        end
    end

endmodule

// File: rtl/mii_fcs_checker.sv
module mii_fcs_checker
    import fcs_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_dv,
    input  logic [3:0]  rx_nib,
    output logic        frame_done,
    output logic        fcs_ok,
    output logic        odd_nibble_err,
    output logic [31:0] rx_fcs,
    output logic [31:0] calc_fcs
);

    logic             sof;
    byte_beat_t       beat;
    logic             eof;
    logic             odd;
    logic [CRC_W-1:0] crc_now;
    logic             resid_hit;

    mii_nibble_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .rx_dv  (rx_dv),
        .rx_nib (rx_nib),
        .sof    (sof),
        .beat   (beat),
        .eof    (eof),
        .odd    (odd)
    );

    crc32_byte_engine u_crc (
        .clk       (clk),
        .rst       (rst),
        .start     (sof),
        .beat      (beat),
        .crc_now   (crc_now),
        .resid_hit (resid_hit)
    );

    fcs_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .start    (sof),
        .beat     (beat),
        .crc_now  (crc_now),
        .eof      (eof),
        .rx_fcs   (rx_fcs),
        .calc_fcs (calc_fcs)
    );

    assign frame_done     = eof;
    assign odd_nibble_err = eof & odd;
    assign fcs_ok         = eof & ~odd & resid_hit;

endmodule

// File: rtl/fcs_chk_sva.sv
module fcs_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        rx_dv,
    input logic        frame_done,
    input logic        fcs_ok,
    input logic        odd_nibble_err,
    input logic [31:0] rx_fcs,
    input logic [31:0] calc_fcs
);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_after_dv_low_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !$past(rx_dv));

    p_ok_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        fcs_ok |-> frame_done);

    p_odd_blocks_ok_r9: assert property (@(posedge clk) disable iff (rst)
        odd_nibble_err |-> (frame_done && !fcs_ok));

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(rx_fcs) && $stable(calc_fcs)));

    p_ok_match_r10: assert property (@(posedge clk) disable iff (rst)
        fcs_ok |=> (rx_fcs == calc_fcs));

endmodule

bind mii_fcs_checker fcs_chk_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .rx_dv          (rx_dv),
    .frame_done     (frame_done),
    .fcs_ok         (fcs_ok),
    .odd_nibble_err (odd_nibble_err),
    .rx_fcs         (rx_fcs),
    .calc_fcs       (calc_fcs)
);

// File: tb/tb_mii_fcs_checker.sv
module tb_mii_fcs_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_dv = 1'b0;
    logic [3:0]  rx_nib = 4'h0;
    logic        frame_done, fcs_ok, odd_nibble_err;
    logic [31:0] rx_fcs, calc_fcs;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mii_fcs_checker dut (
        .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_nib(rx_nib),
        .frame_done(frame_done), .fcs_ok(fcs_ok), .odd_nibble_err(odd_nibble_err),
        .rx_fcs(rx_fcs), .calc_fcs(calc_fcs)
    );

    // len[23:16] seed[15:8] preamble nibbles[7:4] corrupt[3:0]
    localparam logic [23:0] VECS [7] = '{
        24'h2E_11_F_0, 24'h10_22_7_0, 24'h05_33_1_0, 24'h20_44_F_1,
        24'h01_55_3_0, 24'h00_66_0_0, 24'h3C_77_B_1
    };

    logic [7:0]  frm [64];
    int          frm_len;
    logic [31:0] exp_calc, exp_rx;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // independent MSB-first model, result reflected at the end
    function automatic logic [31:0] model_fcs(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[31] ^ frm[k][j];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return ~r;
    endfunction

    function automatic logic [31:0] wire_of(input logic [31:0] f);
        return {f[7:0], f[15:8], f[23:16], f[31:24]};
    endfunction

    task automatic append_fcs(input int plen);
        logic [31:0] f;
        f = model_fcs(plen);
        for (int b = 0; b < 4; b++) frm[plen+b] = f[b*8 +: 8];
        frm_len = plen + 4;
    endtask

    task automatic set_expect(input int plen);
        exp_calc = wire_of(model_fcs(plen));
        exp_rx   = {frm[plen], frm[plen+1], frm[plen+2], frm[plen+3]};
    endtask

    task automatic drive(input logic [3:0] n);
        @(negedge clk);
        rx_dv  = 1'b1;
        rx_nib = n;
    endtask

    task automatic run_frame(input int pre, input bit extra, input bit exp_ok,
                             input string tag);
        for (int i = 0; i < pre; i++) drive(4'h5);
        drive(4'hD);
        for (int k = 0; k < frm_len; k++) begin
            drive(frm[k][3:0]);
            drive(frm[k][7:4]);
        end
        if (extra) drive(4'h3);
        @(negedge clk);
        rx_dv  = 1'b0;
        rx_nib = 4'h0;
        @(negedge clk);
        chk(frame_done === 1'b1, {tag, " R8 frame_done"}, 32'(frame_done), 32'd1);
        chk(fcs_ok === exp_ok, {tag, " R6/R7 fcs_ok"}, 32'(fcs_ok), 32'(exp_ok));
        chk(odd_nibble_err === extra, {tag, " R9 odd flag"}, 32'(odd_nibble_err), 32'(extra));
        @(negedge clk);
        chk(frame_done === 1'b0, {tag, " R8 pulse width"}, 32'(frame_done), 32'd0);
        chk(rx_fcs === exp_rx, {tag, " R3/R10 rx_fcs"}, rx_fcs, exp_rx);
        chk(calc_fcs === exp_calc, {tag, " R4/R10 calc_fcs"}, calc_fcs, exp_calc);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] z8, z16, held_rx, held_calc;
        int plen;

        repeat (3) @(negedge clk);
        chk({frame_done, fcs_ok, odd_nibble_err} === 3'b0, "R1 flags in reset",
            32'({frame_done, fcs_ok, odd_nibble_err}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_fcs === 32'd0 && calc_fcs === 32'd0, "R1 latches after reset",
            rx_fcs ^ calc_fcs, 32'd0);

        // R4: standard check string
        plen = 9;
        for (int k = 0; k < 9; k++) frm[k] = 8'h31 + 8'(k);
        append_fcs(plen);
        set_expect(plen);
        chk(exp_calc === 32'h2639_F4CB, "R4 bench model sanity", exp_calc, 32'h2639_F4CB);
        run_frame(15, 1'b0, 1'b1, "check-string");
        chk(calc_fcs === 32'h2639_F4CB, "R4 known value", calc_fcs, 32'h2639_F4CB);

        // table walk: R2 preamble lengths, R6 good, R7 corrupted
        for (int v = 0; v < 7; v++) begin
            plen = int'(VECS[v][23:16]);
            for (int k = 0; k < plen; k++)
                frm[k] = VECS[v][15:8] * 8'd7 + 8'(k * 13);
            append_fcs(plen);
            if (VECS[v][3:0] != 4'h0) frm[plen/2] = frm[plen/2] ^ 8'h10;
            set_expect(plen);
            run_frame(int'(VECS[v][7:4]), 1'b0, VECS[v][3:0] == 4'h0,
                      $sformatf("R2 vec%0d", v));
        end

        // R5: zero payloads
        for (int k = 0; k < 16; k++) frm[k] = 8'h00;
        append_fcs(8);
        set_expect(8);
        run_frame(7, 1'b0, 1'b1, "R5 zeros8");
        z8 = calc_fcs;
        for (int k = 0; k < 16; k++) frm[k] = 8'h00;
        append_fcs(16);
        set_expect(16);
        run_frame(7, 1'b0, 1'b1, "R5 zeros16");
        z16 = calc_fcs;
        chk(z8 !== 32'd0 && z16 !== 32'd0, "R5 zero run nonzero", z8 & z16, 32'hFFFF_FFFF);
        chk(z8 !== z16, "R5 depends on count", z8, z16);

        // R2/R10: abort inside preamble
        held_rx   = rx_fcs;
        held_calc = calc_fcs;
        for (int i = 0; i < 6; i++) drive(4'h5);
        @(negedge clk);
        rx_dv = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (frame_done) seen = 1'b1;
            end
            chk(!seen, "R2 no done without delimiter", 32'(seen), 32'd0);
        end
        chk(rx_fcs === held_rx && calc_fcs === held_calc, "R10 latches held",
            rx_fcs, held_rx);

        // R9: trailing half byte on an otherwise good frame
        plen = 12;
        for (int k = 0; k < plen; k++) frm[k] = 8'hA0 + 8'(k);
        append_fcs(plen);
        set_expect(plen);
        run_frame(15, 1'b1, 1'b0, "R9 odd");

        // good frame after the error frame
        run_frame(2, 1'b0, 1'b1, "R6 recovery");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule